// File: doc/BRIEF.md
# Off-Time-First PWM Gate Generator

This block drives the switch gate of a boost power stage from a digital control word. Each switching period is a fixed number of clock cycles. Every period opens with a forced blanking interval in which the gate is held low and a counter ramp is pinned at zero. Once blanking ends, the ramp counts up one step per clock. When the ramp reaches the control word captured at the start of the period, the gate turns on and stays on until the period ends. A larger control word therefore gives a longer off interval. The off duty tracks the control value, which is what an average-current boost loop needs.

A peak-current-limit flag can cut the gate within the same clock and keep it low until the next period begins. The cycle-start blanking clears both the turn-on latch and the limit latch, and it takes priority over every other input. A one-clock strobe marks the first cycle of each period so that surrounding logic can align its updates with the switching period.

All pins are plain control and status signals. No data stream crosses the boundary, so there is no valid/ready handshake and the block never applies back-pressure. The control word is level-sampled once per period.

Top module: `offpwm_gate`

## Requirements
- R1: `cyc_start_o` is high for exactly one clock every PERIOD_CYC clocks, and it is high in the first clock after synchronous reset is released.
- R2: In the first TOFF_CYC clocks of each period (period position 0 to TOFF_CYC-1), `gate_o` is low and `ramp_o` is 0.
- R3: At period position p >= TOFF_CYC, `ramp_o` equals p - TOFF_CYC, counting up by one each clock until the period ends.
- R4: With control word k and no limit event, `gate_o` first goes high at period position TOFF_CYC+1+k and stays high through position PERIOD_CYC-1. A word of 0 gives the longest on time, PERIOD_CYC-TOFF_CYC-1 clocks.
- R5: `ctrl_i` is captured only in the clock where `cyc_start_o` is high. A change to `ctrl_i` later in the period has no effect on that period's gate timing.
- R6: A control word of PERIOD_CYC-TOFF_CYC-1 or more keeps `gate_o` low for the whole period.
- R7: If `ilim_i` is high in a clock after blanking while the gate is on, `gate_o` is low in that same clock and stays low for the rest of the period.
- R8: If `ilim_i` is high in a clock after blanking but before the gate has turned on, the gate does not turn on for the rest of that period.
- R9: `ilim_i` asserted during the blanking interval is ignored, and the gate turns on at its normal position.
- R10: The start of a new period clears the limit and turn-on states, so the period after a limit event follows R4 again.
- R11: While `rst_i` is sampled high, `gate_o` is low and `ramp_o` is 0. After release, a new period starts at position 0, even if reset arrived in the middle of a period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; every register updates on the rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| ctrl_i | input | RAMP_W | Unsigned control word that sets the off interval after blanking |
| ilim_i | input | 1 | Peak-current-limit flag, active high |
| gate_o | output | 1 | Switch gate command, high means on |
| ramp_o | output | RAMP_W | Current ramp value |
| cyc_start_o | output | 1 | One-clock strobe in the first clock of each period |

## Verification
The embedded properties assume that `ilim_i` and `ctrl_i` are synchronous to `clk_i` and never unknown. The turn-on hold property also assumes that a limit flag can only remove the gate and never restore it. The bench changes every input only on the falling clock edge and holds the limit flag high for one clock at a chosen period position. It loads the control word in the strobe clock and changes it again mid-period only to show that the change has no effect. The gate outputs are combinational in `ilim_i`, so the bench samples them a short delay after it drives the input and before the next rising edge.

// File: rtl/offpwm_pkg.sv
package offpwm_pkg;

  // Phase of the switching period seen by the gate logic
  typedef enum logic {
    PH_BLANK = 1'b0,
    PH_RAMP  = 1'b1
  } phase_e;

  // Bits needed to hold values 0 .. n-1, never less than one
  function automatic int unsigned span_bits(input int unsigned n);
    int unsigned b;
    b = (n <= 1) ? 1 : $clog2(n);
    return b;
  endfunction

endpackage

// File: rtl/offpwm_timer.sv
module offpwm_timer
  import offpwm_pkg::*;
#(
  parameter int unsigned PERIOD_CYC = 752,
  parameter int unsigned TOFF_CYC   = 25
) (
  input  logic   clk_i,
  input  logic   rst_i,
  output logic   start_o,
  output phase_e phase_o,
  output logic   blank_nxt_o,
  output logic   hold_nxt_o
);

  localparam int unsigned CW = span_bits(PERIOD_CYC);
  localparam logic [CW-1:0] LAST  = CW'(PERIOD_CYC - 1);
  localparam logic [CW-1:0] TOFFV = CW'(TOFF_CYC);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  // Reset folds into the next-state value so that the blanking clear
  // seen by the latches also covers reset
  always_comb begin
    if (rst_i)              cnt_d = '0;
    else if (cnt_q == LAST) cnt_d = '0;
    else                    cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk_i) begin
    cnt_q <= cnt_d;
  end

  assign start_o     = (cnt_q == '0);
  assign phase_o     = (cnt_q < TOFFV) ? PH_BLANK : PH_RAMP;
  assign blank_nxt_o = (cnt_d < TOFFV);
  assign hold_nxt_o  = (cnt_d <= TOFFV);

  initial begin
    a_r1_param_order: assert (TOFF_CYC >= 1 && TOFF_CYC + 1 < PERIOD_CYC)
      else $error("offpwm_timer: TOFF_CYC must be at least 1 and below PERIOD_CYC-1");
  end

  // R1: the strobe never lasts two clocks
  a_r1_strobe_single: assert property (@(posedge clk_i) disable iff (rst_i)
    start_o |=> !start_o);

endmodule

// File: rtl/offpwm_ramp.sv
module offpwm_ramp #(
  parameter int unsigned RAMP_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              hold_nxt_i,
  input  logic              start_i,
  output logic [RAMP_W-1:0] ramp_o
);

  logic [RAMP_W-1:0] ramp_q;

  // Discharged through blanking and the first ramp position, rising after
  always_ff @(posedge clk_i) begin
    if (rst_i || hold_nxt_i) ramp_q <= '0;
    else                     ramp_q <= ramp_q + RAMP_W'(1);
  end

  assign ramp_o = ramp_q;

  // R3: a fresh period always opens from a discharged ramp
  a_r3_ramp_zero_at_start: assert property (@(posedge clk_i) disable iff (rst_i)
    start_i |-> (ramp_q == '0));

endmodule

// File: rtl/offpwm_ctrl_hold.sv
module offpwm_ctrl_hold #(
  parameter int unsigned RAMP_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              start_i,
  input  logic [RAMP_W-1:0] ctrl_i,
  output logic [RAMP_W-1:0] ctrl_o
);

  logic [RAMP_W-1:0] hold_q;

  always_ff @(posedge clk_i) begin
    if (rst_i)        hold_q <= '0;
    else if (start_i) hold_q <= ctrl_i;
  end

  assign ctrl_o = hold_q;

  // R5: the held word moves only at the edge that closes the strobe clock
  a_r5_ctrl_stable: assert property (@(posedge clk_i) disable iff (rst_i)
    !start_i |=> $stable(hold_q));

endmodule

// File: rtl/offpwm_gate_latch.sv
module offpwm_gate_latch (
  input  logic clk_i,
  input  logic rst_i,
  input  logic blank_i,
  input  logic blank_nxt_i,
  input  logic hit_i,
  input  logic ilim_i,
  output logic gate_o
);

  logic lim_q;
  logic on_q;

  // Entering blanking clears both latches and overrides any set request
  always_ff @(posedge clk_i) begin
    if (rst_i || blank_nxt_i) begin
      lim_q <= 1'b0;
      on_q  <= 1'b0;
    end else begin
      lim_q <= lim_q | (ilim_i & ~blank_i);
      on_q  <= on_q | (hit_i & ~blank_i);
    end
  end

  // A live limit flag removes the gate within the same clock
  assign gate_o = on_q & ~lim_q & ~ilim_i;

  // R7: once the limit latch holds, the gate stays low until blanking
  a_r7_limit_holds: assert property (@(posedge clk_i) disable iff (rst_i)
    (lim_q && !blank_nxt_i) |=> !gate_o);

  // R4: an on gate stays on until blanking unless a limit removes it
  a_r4_gate_stays_on: assert property (@(posedge clk_i) disable iff (rst_i)
    (gate_o && !ilim_i && !blank_nxt_i) |=> (gate_o || ilim_i));

  // R10: both latches start each period cleared
  a_r10_clear_in_blank: assert property (@(posedge clk_i) disable iff (rst_i)
    blank_i |-> (!lim_q && !on_q));

endmodule

// File: rtl/offpwm_gate.sv
module offpwm_gate
  import offpwm_pkg::*;
#(
  parameter int unsigned PERIOD_CYC = 752,
  parameter int unsigned TOFF_CYC   = 25,
  parameter int unsigned RAMP_W     = span_bits(PERIOD_CYC - TOFF_CYC)
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [RAMP_W-1:0] ctrl_i,
  input  logic              ilim_i,
  output logic              gate_o,
  output logic [RAMP_W-1:0] ramp_o,
  output logic              cyc_start_o
);

  phase_e            phase;
  logic              start;
  logic              blank;
  logic              blank_nxt;
  logic              hold_nxt;
  logic [RAMP_W-1:0] ramp;
  logic [RAMP_W-1:0] ctrl_q;
  logic              hit;

  offpwm_timer #(
    .PERIOD_CYC (PERIOD_CYC),
    .TOFF_CYC   (TOFF_CYC)
  ) timer_i (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .start_o     (start),
    .phase_o     (phase),
    .blank_nxt_o (blank_nxt),
    .hold_nxt_o  (hold_nxt)
  );

  offpwm_ramp #(
    .RAMP_W (RAMP_W)
  ) ramp_i (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .hold_nxt_i (hold_nxt),
    .start_i    (start),
    .ramp_o     (ramp)
  );

  offpwm_ctrl_hold #(
    .RAMP_W (RAMP_W)
  ) ctrl_i_hold (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .start_i (start),
    .ctrl_i  (ctrl_i),
    .ctrl_o  (ctrl_q)
  );

  assign blank = (phase == PH_BLANK);
  assign hit   = (phase == PH_RAMP) && (ramp >= ctrl_q);

  offpwm_gate_latch latch_i (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .blank_i     (blank),
    .blank_nxt_i (blank_nxt),
    .hit_i       (hit),
    .ilim_i      (ilim_i),
    .gate_o      (gate_o)
  );

  assign ramp_o      = ramp;
  assign cyc_start_o = start;

  // R2: blanking from the timer always keeps the latch output low
  a_r2_blank_gate_low: assert property (@(posedge clk_i) disable iff (rst_i)
    blank |-> !gate_o);

endmodule

// File: tb/offpwm_gate_tb.sv
module offpwm_gate_tb_top;

  localparam int  P     = 40;
  localparam int  T     = 4;
  localparam int  RW    = 6;
  localparam time CLK_T = 10ns;

  logic          clk_i = 1'b0;
  logic          rst_i = 1'b1;
  logic [RW-1:0] ctrl_i = '0;
  logic          ilim_i = 1'b0;
  logic          gate_o;
  logic [RW-1:0] ramp_o;
  logic          cyc_start_o;

  int n_chk  = 0;
  int n_fail = 0;

  always #(CLK_T/2) clk_i = ~clk_i;

  offpwm_gate #(
    .PERIOD_CYC (P),
    .TOFF_CYC   (T),
    .RAMP_W     (RW)
  ) dut_i (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .ctrl_i      (ctrl_i),
    .ilim_i      (ilim_i),
    .gate_o      (gate_o),
    .ramp_o      (ramp_o),
    .cyc_start_o (cyc_start_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic to_start();
    while (!cyc_start_o) @(negedge clk_i);
  endtask

  // One full period: ctrl word k, limit pulse at position lim (-1: none),
  // optional late ctrl change to alt at position 10
  task automatic run_period(input string req, input int k, input int lim,
                            input int alt);
    int gate_bad = 0, ramp_bad = 0, strb_bad = 0;
    int first_on = -1, exp_first = -1;
    to_start();
    for (int c = 0; c < P; c++) begin
      bit killed, exp_g;
      if (c == 0) ctrl_i = RW'(k);
      if (c == 10 && alt >= 0) ctrl_i = RW'(alt);
      ilim_i = (c == lim);
      #1;
      killed = (lim >= T) && (c >= lim);
      exp_g  = (c >= T + 1 + k) && !killed;
      if (exp_g && exp_first < 0) exp_first = c;
      if (gate_o && first_on < 0) first_on = c;
      if (gate_o !== exp_g) gate_bad++;
      if (int'(ramp_o) != ((c < T) ? 0 : c - T)) ramp_bad++;
      if (cyc_start_o !== (c == 0)) strb_bad++;
      @(negedge clk_i);
    end
    ilim_i = 1'b0;
    chk(gate_bad == 0, req, "gate mismatching clocks", gate_bad, 0);
    chk(first_on == exp_first, req, "first gate-on position", first_on, exp_first);
    chk(ramp_bad == 0, "R2/R3", "ramp mismatching clocks", ramp_bad, 0);
    chk(strb_bad == 0, "R1", "strobe mismatching clocks", strb_bad, 0);
  endtask

  task automatic t_reset();
    rst_i = 1'b1;
    repeat (3) @(negedge clk_i);
    chk(gate_o == 1'b0, "R11", "gate in reset", gate_o, 0);
    chk(ramp_o == '0, "R11", "ramp in reset", ramp_o, 0);
    rst_i = 1'b0;
    #1;
    chk(cyc_start_o == 1'b1, "R1", "strobe after release", cyc_start_o, 1);
  endtask

  task automatic t_period();
    int gap = 0;
    to_start();
    @(negedge clk_i);
    gap = 1;
    while (!cyc_start_o) begin
      @(negedge clk_i);
      gap++;
    end
    chk(gap == P, "R1", "strobe spacing", gap, P);
  endtask

  task automatic t_mid_reset();
    int gap = 0;
    to_start();
    ctrl_i = RW'(0);
    repeat (12) @(negedge clk_i);
    rst_i = 1'b1;
    @(negedge clk_i);
    chk(gate_o == 1'b0, "R11", "gate after mid-period reset", gate_o, 0);
    chk(ramp_o == '0, "R11", "ramp after mid-period reset", ramp_o, 0);
    rst_i = 1'b0;
    #1;
    chk(cyc_start_o == 1'b1, "R11", "period restarts at release", cyc_start_o, 1);
    @(negedge clk_i);
    gap = 1;
    while (!cyc_start_o) begin
      @(negedge clk_i);
      gap++;
    end
    chk(gap == P, "R11", "first period length after reset", gap, P);
  endtask

  initial begin
    #(CLK_T * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    @(negedge clk_i);
    t_reset();
    t_period();
    run_period("R4", 0, -1, -1);
    run_period("R4", 10, -1, -1);
    run_period("R5", 12, -1, 0);
    run_period("R6", P - T - 1, -1, -1);
    run_period("R6", P - T - 2 + 2, -1, -1);
    run_period("R4", P - T - 2, -1, -1);
    run_period("R7", 5, 20, -1);
    run_period("R10", 5, -1, -1);
    run_period("R8", 20, 6, -1);
    run_period("R9", 5, T - 1, -1);
    run_period("R9", 5, 1, -1);
    t_mid_reset();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule